// File: doc/BRIEF.md
# Late-Operand Bitwise Function Unit

This unit computes one of ten bitwise functions of two operand words, `op_a` and `op_b`. Two of the functions also take a third word, `op_c`. For every bit position, two candidate values are chosen by the function code from a small precomputed set: zero, one, `op_a`, the complement of `op_a`, and `op_c`. The bit of `op_b` at that position then picks between the two candidates. Because `op_b` only drives the last 2:1 stage, it may arrive later in the cycle than the other inputs.

An optional combine mode folds the bitwise result into fixed-size chunks of 8, 16, 32 or 64 bits. Each chunk becomes all ones if any of its bits is set and all zeros otherwise. The result is registered: a valid input can be accepted every cycle, and its result appears one cycle later.

Top module: `bitsel_unit`

## Requirements
- R1: Function codes 0 to 7 give, per bit: 0 a&b, 1 a&~b, 2 a^b, 3 a|b, 4 ~(a|b), 5 ~(a^b), 6 a|~b, 7 ~(a&b).
- R2: Function code 8 gives `op_a` where the `op_b` bit is 1 and `op_c` where it is 0.
- R3: Function code 9 gives `op_c` where the `op_b` bit is 1 and `op_a` where it is 0.
- R4: Function codes 10 to 15 give an all-zero result.
- R5: With `merge_en` high, the result is split into chunks whose width is set by `merge_size`: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. Every bit of a chunk equals the OR of that chunk's bits in the plain function result.
- R6: `out_valid` equals `in_valid` delayed by one clock. A result captured at one rising edge is visible after that edge.
- R7: While `in_valid` is low, `result` keeps its previous value.
- R8: While reset is asserted, `out_valid` is 0 and `result` is all zeros.
- R9: For function codes 0 to 7, `op_c` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and function code are valid |
| op_a | input | W | First operand |
| op_b | input | W | Per-bit steering operand |
| op_c | input | W | Third operand for the two select functions |
| func | input | 4 | Function code |
| merge_en | input | 1 | Combine-mode enable |
| merge_size | input | 2 | Chunk width selector |
| out_valid | output | 1 | Result is valid |
| result | output | W | Registered result |

## Verification
The assertions assume that `func`, `merge_en` and the operands are settled at the rising edge where `in_valid` is high. They also assume that reset is applied for at least one edge before use. The bench changes every input only on the falling edge, so each sample is taken at a clean, stable point. It mixes random operands with random function codes, including the unused codes 10 to 15, and random chunk sizes. It also adds directed all-zero, all-one and single-bit words, which sit at the edges of the chunk OR.

// File: rtl/bitsel_unit.sv
module bitsel_unit #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] op_c,
  input  logic [3:0]   func,
  input  logic         merge_en,
  input  logic [1:0]   merge_size,
  output logic         out_valid,
  output logic [W-1:0] result
);
  localparam int NSZ = 4;
  localparam int MINCH = 8;

  localparam logic [2:0] K_ZERO = 3'd0;
  localparam logic [2:0] K_ONE  = 3'd1;
  localparam logic [2:0] K_A    = 3'd2;
  localparam logic [2:0] K_NA   = 3'd3;
  localparam logic [2:0] K_C    = 3'd4;

  logic [2:0]   hi_k, lo_k;
  logic [W-1:0] not_a, hi_v, lo_v, raw, nxt;
  logic [W-1:0] folded [NSZ];

  assign not_a = ~op_a;

  always_comb begin
    hi_k = K_ZERO;
    lo_k = K_ZERO;
    case (func)
      4'd0: begin hi_k = K_A;    lo_k = K_ZERO; end
      4'd1: begin hi_k = K_ZERO; lo_k = K_A;    end
      4'd2: begin hi_k = K_NA;   lo_k = K_A;    end
      4'd3: begin hi_k = K_ONE;  lo_k = K_A;    end
      4'd4: begin hi_k = K_ZERO; lo_k = K_NA;   end
      4'd5: begin hi_k = K_A;    lo_k = K_NA;   end
      4'd6: begin hi_k = K_A;    lo_k = K_ONE;  end
      4'd7: begin hi_k = K_NA;   lo_k = K_ONE;  end
      4'd8: begin hi_k = K_A;    lo_k = K_C;    end
      4'd9: begin hi_k = K_C;    lo_k = K_A;    end
      default: begin hi_k = K_ZERO; lo_k = K_ZERO; end
    endcase
  end

  function automatic logic [W-1:0] pick(input logic [2:0] k, input logic [W-1:0] a,
                                        input logic [W-1:0] na, input logic [W-1:0] c);
    case (k)
      K_ONE:   pick = '1;
      K_A:     pick = a;
      K_NA:    pick = na;
      K_C:     pick = c;
      default: pick = '0;
    endcase
  endfunction

  assign hi_v = pick(hi_k, op_a, not_a, op_c);
  assign lo_v = pick(lo_k, op_a, not_a, op_c);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign raw[i] = op_b[i] ? hi_v[i] : lo_v[i];
  end

  for (genvar s = 0; s < NSZ; s++) begin : g_sz
    localparam int CS = MINCH << s;
    for (genvar j = 0; j < W / CS; j++) begin : g_ch
      assign folded[s][j*CS +: CS] = {CS{|raw[j*CS +: CS]}};
    end
  end

  assign nxt = merge_en ? folded[merge_size] : raw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt;
    end
  end
endmodule

module bitsel_unit_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic [W-1:0] op_c,
  input logic [3:0]   func,
  input logic         merge_en,
  input logic [1:0]   merge_size,
  input logic         out_valid,
  input logic [W-1:0] result
);
  // R6
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R6
  idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R7
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
  // R1
  and_func_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !merge_en && func == 4'd0) |=> result == ($past(op_a) & $past(op_b)));
  // R2
  mux_func_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !merge_en && func == 4'd8) |=>
      result == (($past(op_a) & $past(op_b)) | ($past(op_c) & ~$past(op_b))));
  // R4
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && func >= 4'd10) |=> result == '0);
  // R5
  byte_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && merge_en && merge_size == 2'd0) |=>
      (result[7:0] == 8'h00 || result[7:0] == 8'hFF));
endmodule

bind bitsel_unit bitsel_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
  .op_c(op_c), .func(func), .merge_en(merge_en), .merge_size(merge_size),
  .out_valid(out_valid), .result(result)
);

// File: tb/tb_bitsel_unit.sv
module tb_bitsel_unit;
  localparam int W = 64;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0, op_c = '0;
  logic [3:0]   func = '0;
  logic         merge_en = 1'b0;
  logic [1:0]   merge_size = '0;
  logic         out_valid;
  logic [W-1:0] result;

  int checks = 0;
  int failures = 0;
  logic [W-1:0] last_res = '0;

  bitsel_unit #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .op_c(op_c), .func(func), .merge_en(merge_en), .merge_size(merge_size),
    .out_valid(out_valid), .result(result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [W-1:0] plain(input logic [3:0] f, input logic [W-1:0] a,
                                         input logic [W-1:0] b, input logic [W-1:0] c);
    case (f)
      4'd0: plain = a & b;
      4'd1: plain = a & ~b;
      4'd2: plain = a ^ b;
      4'd3: plain = a | b;
      4'd4: plain = ~(a | b);
      4'd5: plain = ~(a ^ b);
      4'd6: plain = a | ~b;
      4'd7: plain = ~(a & b);
      4'd8: plain = (a & b) | (c & ~b);
      4'd9: plain = (c & b) | (a & ~b);
      default: plain = '0;
    endcase
  endfunction

  function automatic logic [W-1:0] fold(input logic [W-1:0] v, input logic [1:0] sz);
    int cs;
    cs = 8 << sz;
    fold = '0;
    for (int j = 0; j < W; j += cs) begin
      logic any;
      any = 1'b0;
      for (int k = 0; k < cs; k++) any |= v[j+k];
      for (int k = 0; k < cs; k++) fold[j+k] = any;
    end
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [3:0] f, input logic [W-1:0] a,
                      input logic [W-1:0] b, input logic [W-1:0] c,
                      input logic me, input logic [1:0] ms, input string tag);
    logic [W-1:0] exp;
    @(negedge clk);
    in_valid = v; func = f; op_a = a; op_b = b; op_c = c;
    merge_en = me; merge_size = ms;
    exp = plain(f, a, b, c);
    if (me) exp = fold(exp, ms);
    if (!v) exp = last_res;
    @(posedge clk);
    #1;
    check("R6 out_valid", {{(W-1){1'b0}}, out_valid}, {{(W-1){1'b0}}, v});
    check(tag, result, exp);
    last_res = exp;
  endtask

  function automatic logic [W-1:0] rnd();
    rnd = {$urandom(), $urandom()};
  endfunction

  function automatic string tag_of(input logic [3:0] f, input logic me);
    if (me) tag_of = "R5 fold";
    else if (f < 4'd8) tag_of = "R1 func";
    else if (f == 4'd8) tag_of = "R2 mux";
    else if (f == 4'd9) tag_of = "R3 mux_rev";
    else tag_of = "R4 unused";
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(posedge clk);
    #1;
    // R8
    check("R8 reset valid", {{(W-1){1'b0}}, out_valid}, '0);
    check("R8 reset result", result, '0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int f = 0; f < 16; f++) begin
      step(1'b1, f[3:0], '0, '0, '0, 1'b0, 2'd0, tag_of(f[3:0], 1'b0));
      step(1'b1, f[3:0], '1, '1, '1, 1'b0, 2'd0, tag_of(f[3:0], 1'b0));
      step(1'b1, f[3:0], 64'h00FF_00FF_F0F0_3C3C, 64'h0F0F_FFFF_0000_AAAA,
           64'h1234_5678_9ABC_DEF0, 1'b0, 2'd0, tag_of(f[3:0], 1'b0));
    end

    for (int s = 0; s < 4; s++) begin
      step(1'b1, 4'd0, '0, '0, '0, 1'b1, s[1:0], "R5 fold zero");
      step(1'b1, 4'd3, 64'h0000_0000_0000_0001, '0, '0, 1'b1, s[1:0], "R5 fold lsb");
      step(1'b1, 4'd3, 64'h8000_0000_0000_0000, '0, '0, 1'b1, s[1:0], "R5 fold msb");
      step(1'b1, 4'd9, 64'h0100_0000_0001_0000, '0, '0, 1'b1, s[1:0], "R5 fold mid");
    end

    for (int f = 0; f < 8; f++) begin
      logic [W-1:0] a, b;
      a = rnd(); b = rnd();
      step(1'b1, f[3:0], a, b, '0, 1'b0, 2'd0, "R9 c low");
      step(1'b1, f[3:0], a, b, '1, 1'b0, 2'd0, "R9 c high");
    end

    step(1'b1, 4'd5, rnd(), rnd(), rnd(), 1'b0, 2'd0, "R1 pre-idle");
    step(1'b0, 4'd3, '1, '1, '1, 1'b0, 2'd0, "R7 hold");
    step(1'b0, 4'd0, rnd(), rnd(), rnd(), 1'b1, 2'd3, "R7 hold merge");

    for (int n = 0; n < 600; n++) begin
      logic [3:0] f;
      logic me, v;
      logic [1:0] ms;
      f = 4'($urandom_range(0, 15));
      me = ($urandom_range(0, 3) == 0);
      ms = 2'($urandom_range(0, 3));
      v = ($urandom_range(0, 7) != 0);
      step(v, f, rnd(), rnd(), rnd(), me, ms, v ? tag_of(f, me) : "R7 hold rnd");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule